// File: doc/BRIEF.md
# Sectored Direct-Mapped Instruction Cache

This block is the storage and lookup part of an instruction-fetch cache. Every fetch address maps to exactly one line, so no replacement choice is made. A line holds 128 bytes, split into four 32-byte sectors. Each line keeps one tag and one valid bit per sector. A fetch that finds its tag and its sector valid returns the whole 32-byte sector one cycle later.

A fetch that misses asks for that one sector only, through a single-cycle request carrying the sector-aligned address. The fetch side then stays blocked until that sector arrives on the fill port. A fill writes one sector per cycle. A fill whose tag differs from the line's tag takes the line over and leaves only the new sector valid. A global invalidate input clears every valid bit in one cycle.

The data array has a single port. Each cycle it does one read or one write, never both, and a fill has priority over a fetch.

Top module: `ifetch_sector_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_hit` and `refill_req` are 0 and no sector is valid.
- R2: A fetch that `fetch_ready` accepts, whose address matches the line tag and whose sector bit is valid, gives `rsp_hit`=1 in the next cycle. `rsp_data` then carries the 256 bits last filled into that sector. Byte offset bits [4:0] of the fetch address are ignored.
- R3: An accepted fetch that misses gives, in the next cycle, a one-cycle `refill_req` pulse with `rsp_hit`=0. `refill_addr` equals the fetch address with bits [4:0] forced to zero.
- R4: After a miss, `fetch_ready` stays 0 until a fill arrives whose bits [ADDR_W-1:5] equal those of `refill_addr`. It is 1 again in the cycle after that fill. Fills to other sectors do not end the wait.
- R5: Sector select is address bits [6:5]. Filling one sector makes only that sector hit, and other sectors of the same line still miss.
- R6: Line index is bits [7+IDX_W-1:7] and the tag is the bits above it. A fill whose tag differs from the line's stored tag replaces the tag and leaves only the filled sector valid. The old tag then misses in every sector.
- R7: A fill whose tag equals the line's tag adds its sector and keeps the other valid sectors hitting.
- R8: In a cycle with `fill_valid`=1, `fetch_ready` is 0 and the fetch is not taken: the next cycle shows neither `rsp_hit` nor `refill_req`.
- R9: In a cycle with `flush_all`=1, `fetch_ready` is 0. Every sector is invalid afterwards, so no hit is reported in the next cycle and later fetches miss until refilled.
- R10: A flush and a fill in the same cycle leave the filled sector invalid. The flush wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Fetch taken this cycle |
| rsp_hit | output | 1 | Hit for the fetch taken in the previous cycle |
| rsp_data | output | SECTOR_BYTES*8 | Sector contents, meaningful when `rsp_hit`=1 |
| refill_req | output | 1 | One-cycle request for a missing sector |
| refill_addr | output | ADDR_W | Sector-aligned address of the requested sector |
| fill_valid | input | 1 | Fill write this cycle |
| fill_addr | input | ADDR_W | Address of the sector being filled |
| fill_data | input | SECTOR_BYTES*8 | Sector contents to store |
| flush_all | input | 1 | Invalidate every sector |

## Verification
Fetches are tried under several patterns:
- A cold sector tells a true miss apart from a stale hit.
- A neighbouring sector of a filled line shows that validity is tracked per sector and not per line.
- A second sector with the same tag shows that fills add to a line.
- A conflicting tag at the same index shows that a fill takes the line over.

Fetches are also applied while a fill or a flush is active, and while a miss is pending with unrelated fills arriving. These cases separate the port-priority and blocking rules from plain lookup. Varied byte offsets confirm that only sector, index and tag bits select the data.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [0:0] {
    MC_IDLE = 1'b0,
    MC_WAIT = 1'b1
  } ifc_mc_state_e;

  function automatic logic [3:0] sec_onehot(input logic [1:0] sel);
    logic [3:0] m;
    m = 4'b0001 << sel;
    return m;
  endfunction

endpackage

// File: rtl/ifc_data_ram.sv
module ifc_data_ram #(
  parameter int AW = 6,
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  // single port: one access per cycle, write or read
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem_q[addr] <= wdata;
      end else begin
        rdata_q <= mem_q[addr];
      end
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 21,
  parameter int SEC_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  input  logic [$clog2(SEC_N)-1:0] lk_sec,
  output logic                     lk_hit,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [$clog2(SEC_N)-1:0] wr_sec,
  input  logic                     flush
);

  localparam int IDX_W = $clog2(LINES);

  logic [TAG_W-1:0] tag_q [LINES];
  logic [SEC_N-1:0] val_q [LINES];
  logic [SEC_N-1:0] wr_mask;

  assign wr_mask = SEC_N'(1) << wr_sec;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic [SEC_N-1:0] val_d;
    logic             sel;
    logic             same_tag;
    logic             tag_en;

    assign sel      = wr_en && (wr_idx == IDX_W'(gi));
    assign same_tag = (tag_q[gi] == wr_tag);
    assign tag_en   = sel && !same_tag;

    always_comb begin
      val_d = val_q[gi];
      if (sel) begin
        if (same_tag) val_d = val_q[gi] | wr_mask;
        else          val_d = wr_mask;
      end
      if (flush) val_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q[gi] <= '0;
      else        val_q[gi] <= val_d;
    end

    always_ff @(posedge clk) begin
      if (tag_en) tag_q[gi] <= wr_tag;
    end
  end

  assign lk_hit = val_q[lk_idx][lk_sec] && (tag_q[lk_idx] == lk_tag);

  AST_FLUSH_KILLS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit) else $error("flush left a hit"); // R9

  AST_NEW_TAG_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(flush) && $past(tag_q[wr_idx]) != $past(wr_tag))
      |-> $countones(val_q[$past(wr_idx)]) == 1) else $error("tag replace kept sectors"); // R6

endmodule

// File: rtl/ifc_miss_ctrl.sv
module ifc_miss_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_take,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              idle,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr
);
  import ifc_pkg::*;

  ifc_mc_state_e    state_q, state_d;
  logic             req_q, req_d;
  logic [ADDR_W-1:0] addr_q;
  logic             addr_en;
  logic             fill_match;

  assign fill_match = fill_en && (fill_addr[ADDR_W-1:OFF_W] == addr_q[ADDR_W-1:OFF_W]);
  assign addr_en    = miss_take;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    case (state_q)
      MC_IDLE: if (miss_take) begin
        state_d = MC_WAIT;
        req_d   = 1'b1;
      end
      MC_WAIT: if (fill_match) state_d = MC_IDLE;
      default: state_d = MC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MC_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= {miss_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
  end

  assign idle     = (state_q == MC_IDLE);
  assign req      = req_q;
  assign req_addr = addr_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q) else $error("refill request longer than one cycle"); // R3

  AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !idle) else $error("request without waiting"); // R4

endmodule

// File: rtl/ifetch_sector_cache.sv
module ifetch_sector_cache #(
  parameter int ADDR_W       = 32,
  parameter int LINES        = 16,
  parameter int SECTOR_BYTES = 32,
  parameter int SECTORS      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fetch_req,
  input  logic [ADDR_W-1:0]         fetch_addr,
  output logic                      fetch_ready,
  output logic                      rsp_hit,
  output logic [SECTOR_BYTES*8-1:0] rsp_data,
  output logic                      refill_req,
  output logic [ADDR_W-1:0]         refill_addr,
  input  logic                      fill_valid,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic [SECTOR_BYTES*8-1:0] fill_data,
  input  logic                      flush_all
);

  localparam int OFF_W    = $clog2(SECTOR_BYTES);
  localparam int SEC_W    = $clog2(SECTORS);
  localparam int IDX_W    = $clog2(LINES);
  localparam int LINE_LSB = OFF_W + SEC_W;
  localparam int TAG_LSB  = LINE_LSB + IDX_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int DW       = SECTOR_BYTES * 8;
  localparam int RAM_AW   = IDX_W + SEC_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // address fields
  logic [SEC_W-1:0] f_sec, w_sec;
  logic [IDX_W-1:0] f_idx, w_idx;
  logic [TAG_W-1:0] f_tag, w_tag;
  logic             ofs_unused;

  assign f_sec = fetch_addr[LINE_LSB-1:OFF_W];
  assign f_idx = fetch_addr[TAG_LSB-1:LINE_LSB];
  assign f_tag = fetch_addr[ADDR_W-1:TAG_LSB];
  assign w_sec = fill_addr[LINE_LSB-1:OFF_W];
  assign w_idx = fill_addr[TAG_LSB-1:LINE_LSB];
  assign w_tag = fill_addr[ADDR_W-1:TAG_LSB];
  assign ofs_unused = ^{fetch_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic mc_idle;
  logic take;
  logic lk_hit;
  logic hit_d, hit_q;

  // fill and flush own the cycle; a pending miss blocks new fetches
  assign fetch_ready = mc_idle && !fill_valid && !flush_all;
  assign take        = fetch_req && fetch_ready;
  assign hit_d       = take && lk_hit;

  ifc_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .SEC_N (SECTORS)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .lk_idx (f_idx),
    .lk_tag (f_tag),
    .lk_sec (f_sec),
    .lk_hit (lk_hit),
    .wr_en  (fill_valid),
    .wr_idx (w_idx),
    .wr_tag (w_tag),
    .wr_sec (w_sec),
    .flush  (flush_all)
  );

  ifc_miss_ctrl #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_miss (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .miss_take (take && !lk_hit),
    .miss_addr (fetch_addr),
    .fill_en   (fill_valid),
    .fill_addr (fill_addr),
    .idle      (mc_idle),
    .req       (refill_req),
    .req_addr  (refill_addr)
  );

  logic              ram_en;
  logic [RAM_AW-1:0] ram_addr;

  assign ram_en   = fill_valid || take;
  assign ram_addr = fill_valid ? {w_idx, w_sec} : {f_idx, f_sec};

  ifc_data_ram #(
    .AW (RAM_AW),
    .DW (DW)
  ) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (fill_valid),
    .addr  (ram_addr),
    .wdata (fill_data),
    .rdata (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) hit_q <= 1'b0;
    else          hit_q <= hit_d;
  end
  assign rsp_hit = hit_q;

  AST_FILL_STEALS_PORT: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(fill_valid) |-> !rsp_hit && !refill_req) else $error("fetch served during fill"); // R8

  AST_NO_HIT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(flush_all) |-> !rsp_hit) else $error("hit right after flush"); // R9

  AST_HIT_OR_MISS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(rsp_hit && refill_req)) else $error("hit and refill together"); // R2

  AST_WAIT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_i_n)
    refill_req |-> !fetch_ready) else $error("fetch accepted while waiting"); // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> !rsp_hit && !refill_req) else $error("outputs active in reset"); // R1

endmodule

// File: tb/sim_ifetch_sector_cache.sv
module sim_ifetch_sector_cache;

  localparam int AW = 32;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_ready;
  logic          rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          refill_req;
  logic [AW-1:0] refill_addr;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          flush_all = 1'b0;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ifetch_sector_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .refill_req(refill_req), .refill_addr(refill_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .flush_all(flush_all)
  );

  // behavioural reference: line table keyed by index, sector memory by key
  logic [20:0]   m_tag [16];
  logic [3:0]    m_val [16];
  logic [DW-1:0] m_mem [int];
  bit            m_wait = 0;
  logic [AW-1:0] m_pend = '0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8{a ^ 32'hA5C3_0F1E}};
  endfunction

  task automatic chk(input string tg, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic fq, input logic [AW-1:0] fa,
                      input logic fv, input logic [AW-1:0] la, input logic fl);
    bit e_rdy, acc, e_hit, e_req;
    int fi, fs, li, ls;
    logic [DW-1:0] e_dat;
    logic [AW-1:0] e_adr;
    fetch_req = fq; fetch_addr = fa;
    fill_valid = fv; fill_addr = la; fill_data = pat(la);
    flush_all = fl;
    #1;
    e_rdy = !m_wait && !fv && !fl;
    chk(tg, "fetch_ready", DW'(fetch_ready), DW'(e_rdy));
    fi = int'(fa[10:7]); fs = int'(fa[6:5]);
    li = int'(la[10:7]); ls = int'(la[6:5]);
    acc   = fq && e_rdy;
    e_hit = acc && m_val[fi][fs] && (m_tag[fi] == fa[31:11]);
    e_dat = e_hit ? m_mem[fi*4+fs] : '0;
    e_req = acc && !e_hit;
    e_adr = {fa[31:5], 5'b0};
    if (fv) begin
      m_mem[li*4+ls] = pat(la);
      if (m_tag[li] == la[31:11] && m_val[li] != 4'b0) m_val[li] = m_val[li] | (4'b1 << ls);
      else begin m_tag[li] = la[31:11]; m_val[li] = 4'b1 << ls; end
      if (m_wait && la[31:5] == m_pend[31:5]) m_wait = 0;
    end
    if (fl) for (int k = 0; k < 16; k++) m_val[k] = '0;
    if (e_req) begin m_wait = 1; m_pend = e_adr; end
    @(posedge clk);
    @(negedge clk);
    chk(tg, "rsp_hit", DW'(rsp_hit), DW'(e_hit));
    chk(tg, "refill_req", DW'(refill_req), DW'(e_req));
    if (e_hit) chk(tg, "rsp_data", rsp_data, e_dat);
    if (e_req) chk(tg, "refill_addr", DW'(refill_addr), DW'(e_adr));
  endtask

  task automatic fetch(input string tg, input logic [AW-1:0] a); step(tg, 1, a, 0, '0, 0); endtask
  task automatic fill (input string tg, input logic [AW-1:0] a); step(tg, 0, '0, 1, a, 0); endtask

  localparam logic [AW-1:0] A  = 32'h0000_1240;  // index 4, sector 2
  localparam logic [AW-1:0] A0 = 32'h0000_1200;  // index 4, sector 0
  localparam logic [AW-1:0] C  = 32'h0000_1A40;  // index 4, other tag

  initial begin
    for (int k = 0; k < 16; k++) begin m_tag[k] = '1; m_val[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "rsp_hit in reset", DW'(rsp_hit), '0);
    chk("R1", "refill_req in reset", DW'(refill_req), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step("R1", 0, '0, 0, '0, 0);
    fetch("R1", A);                    // cold: must miss
    fetch("R4", A); fetch("R4", A);    // blocked while waiting
    fill("R4", 32'h0000_2000);         // unrelated fill keeps waiting
    fetch("R4", A);
    fill("R4", A);                     // matching fill ends wait
    fetch("R2", A + 7);                // offset ignored
    fetch("R2", A + 31);
    fetch("R5", A0);                   // same line, other sector misses
    fill("R5", A0);
    fetch("R7", A0 + 3);
    fetch("R7", A);
    fetch("R6", C);                    // conflicting tag
    fill("R6", C);
    fetch("R6", C);
    fetch("R6", A);                    // old tag gone
    fill("R6", A);
    fetch("R6", A0);                   // other sector cleared by replace
    fill("R6", A0);
    step("R8", 1, A, 1, 32'h0000_0080, 0);   // fill beats fetch
    fetch("R8", A);
    step("R9", 1, A, 0, '0, 1);               // flush with fetch
    fetch("R9", A);
    fill("R9", A);
    fetch("R9", A);
    step("R10", 0, '0, 1, 32'h0000_0320, 1);  // flush + fill together
    fetch("R10", 32'h0000_0320);
    fill("R10", 32'h0000_0320);
    for (int n = 0; n < 16; n++) begin
      logic [AW-1:0] a;
      a = {17'h0, 4'(n * 5), 4'(n), 2'(n), 5'(n * 3)};
      fetch("R3", a);
      fill("R3", a);
      fetch("R2", a);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule